// File: doc/BRIEF.md
# Dual-Clock Debug Communications Mailbox

This block moves single words in both directions between a processor clock domain and a debug clock domain whose clocks are unrelated. There is one word register in each direction. The outbound register carries words from the processor to the debugger, and the inbound register carries words from the debugger to the processor. Each register has a handshake flag. W means the outbound register is occupied and R means the inbound register is occupied. A write on the producing side sets the flag. A read on the consuming side clears it.

Both sides poll a 32-bit status word that shows both flags, each synchronized to that side's own clock. The processor can use two level interrupts instead of polling. One is high while the outbound register is free. The other is high while an inbound word is waiting.

Both sides use single-cycle parallel read and write strobes. Each flag crosses domains as a pair of toggles, one toggle owned by each domain, passed through multi-flop synchronizers. Every clock domain has its own synchronous active-high reset.

Top module: `dcc_mbx`

## Requirements
- R1: A processor write while W is clear stores the word, and W (status bit 1) reads as 1 in the processor status from the cycle after the write edge.
- R2: A debugger read while its view of W is 1 places the outbound word on the debugger read-data output after that edge and clears W in the debugger status at the same time.
- R3: A debugger write while its view of R is clear stores the word and sets R (status bit 0) in the debugger status after that edge. A processor read while R is set returns the word after that edge and clears R in the processor status.
- R4: A write made while the writer's own view of the matching flag is set is ignored, and the stored word is kept.
- R5: A read made while the reader's view of the matching flag is clear leaves the read-data output and the flags unchanged.
- R6: Both status words carry W at bit 1 and R at bit 0, and bits 31 to 2 read as zero.
- R7: The processor outbound-free interrupt is high exactly while the processor status shows W clear. The inbound-waiting interrupt is high exactly while the processor status shows R set.
- R8: While reset is held, both status words read 0, both read-data outputs read 0, the outbound-free interrupt is 1 and the inbound-waiting interrupt is 0.
- R9: A flag change made in one domain appears in the other domain's status within SYNC_STAGES+1 cycles of that domain's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_clk | input | 1 | Processor clock |
| proc_rst | input | 1 | Processor-domain synchronous reset, active high |
| proc_wr_en | input | 1 | Processor write strobe to the outbound register |
| proc_wr_data | input | 32 | Outbound word |
| proc_rd_en | input | 1 | Processor read strobe from the inbound register |
| proc_rd_data | output | 32 | Last inbound word taken by the processor |
| proc_status | output | 32 | Processor view: bit 1 W, bit 0 R |
| irq_tx_free | output | 1 | High while the outbound register is free |
| irq_rx_full | output | 1 | High while an inbound word is waiting |
| dbg_clk | input | 1 | Debug clock |
| dbg_rst | input | 1 | Debug-domain synchronous reset, active high |
| dbg_wr_en | input | 1 | Debugger write strobe to the inbound register |
| dbg_wr_data | input | 32 | Inbound word |
| dbg_rd_en | input | 1 | Debugger read strobe from the outbound register |
| dbg_rd_data | output | 32 | Last outbound word taken by the debugger |
| dbg_status | output | 32 | Debugger view: bit 1 W, bit 0 R |

## Verification
Words are sent in both directions as walking ones, all zeros, all ones, alternating patterns and a multiplicative sequence. A stuck, swapped or lost data bit therefore shows up on some bit position, and a crossed lane shows up as a word in the wrong direction. Back-to-back writes to a full register separate a design that honours its own flag from one that overwrites the stored word. Reads of an empty register separate a gated read from one that reloads stale data. During each transfer the bench polls the opposite domain's status with a cycle bound, which exposes a missing synchronizer stage or a toggle that never propagates.

// File: rtl/dcc_mbx_pkg.sv
package dcc_mbx_pkg;
  localparam int STAT_W   = 32;
  localparam int W_POS    = 1;
  localparam int R_POS    = 0;

  function automatic logic [STAT_W-1:0] pack_status(input logic w, input logic r);
    logic [STAT_W-1:0] s;
    s        = '0;
    s[W_POS] = w;
    s[R_POS] = r;
    return s;
  endfunction
endpackage

// File: rtl/dcc_mbx_sync.sv
module dcc_mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dcc_mbx_flag.sv
module dcc_mbx_flag #(
  parameter int STAGES = 2
) (
  input  logic set_clk,
  input  logic set_rst,
  input  logic set_req,
  output logic set_fire,
  output logic set_view,
  input  logic clr_clk,
  input  logic clr_rst,
  input  logic clr_req,
  output logic clr_fire,
  output logic clr_view
);
  logic set_tgl, clr_tgl;
  logic set_tgl_s, clr_tgl_s;

  // Setting side: the flag is up while its toggle differs from the echoed clear toggle
  assign set_view = set_tgl ^ clr_tgl_s;
  assign set_fire = set_req & ~set_view;

  always_ff @(posedge set_clk) begin
    if (set_rst)       set_tgl <= 1'b0;
    else if (set_fire) set_tgl <= ~set_tgl;
  end

  // Clearing side: the flag is up while the echoed set toggle differs from its own
  assign clr_view = set_tgl_s ^ clr_tgl;
  assign clr_fire = clr_req & clr_view;

  always_ff @(posedge clr_clk) begin
    if (clr_rst)       clr_tgl <= 1'b0;
    else if (clr_fire) clr_tgl <= ~clr_tgl;
  end

  dcc_mbx_sync #(.STAGES(STAGES)) u_set_to_clr (
    .clk (clr_clk),
    .rst (clr_rst),
    .d   (set_tgl),
    .q   (set_tgl_s)
  );

  dcc_mbx_sync #(.STAGES(STAGES)) u_clr_to_set (
    .clk (set_clk),
    .rst (set_rst),
    .d   (clr_tgl),
    .q   (clr_tgl_s)
  );
endmodule

// File: rtl/dcc_mbx_lane.sv
module dcc_mbx_lane #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_flag,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag
);
  logic              take_wr, take_rd;
  logic [DATA_W-1:0] word_q;

  dcc_mbx_flag #(.STAGES(STAGES)) u_flag (
    .set_clk  (wr_clk),
    .set_rst  (wr_rst),
    .set_req  (wr_en),
    .set_fire (take_wr),
    .set_view (wr_flag),
    .clr_clk  (rd_clk),
    .clr_rst  (rd_rst),
    .clr_req  (rd_en),
    .clr_fire (take_rd),
    .clr_view (rd_flag)
  );

  // Word held in the writer's domain; it is stable whenever the reader sees the flag
  always_ff @(posedge wr_clk) begin
    if (wr_rst)       word_q <= '0;
    else if (take_wr) word_q <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)       rd_data <= '0;
    else if (take_rd) rd_data <= word_q;
  end
endmodule

// File: rtl/dcc_mbx.sv
module dcc_mbx
  import dcc_mbx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              proc_clk,
  input  logic              proc_rst,
  input  logic              proc_wr_en,
  input  logic [DATA_W-1:0] proc_wr_data,
  input  logic              proc_rd_en,
  output logic [DATA_W-1:0] proc_rd_data,
  output logic [STAT_W-1:0] proc_status,
  output logic              irq_tx_free,
  output logic              irq_rx_full,
  input  logic              dbg_clk,
  input  logic              dbg_rst,
  input  logic              dbg_wr_en,
  input  logic [DATA_W-1:0] dbg_wr_data,
  input  logic              dbg_rd_en,
  output logic [DATA_W-1:0] dbg_rd_data,
  output logic [STAT_W-1:0] dbg_status
);
  logic w_at_proc, w_at_dbg, r_at_proc, r_at_dbg;

  // Outbound lane: processor produces, debugger consumes
  dcc_mbx_lane #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_out (
    .wr_clk  (proc_clk),
    .wr_rst  (proc_rst),
    .wr_en   (proc_wr_en),
    .wr_data (proc_wr_data),
    .wr_flag (w_at_proc),
    .rd_clk  (dbg_clk),
    .rd_rst  (dbg_rst),
    .rd_en   (dbg_rd_en),
    .rd_data (dbg_rd_data),
    .rd_flag (w_at_dbg)
  );

  // Inbound lane: debugger produces, processor consumes
  dcc_mbx_lane #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_in (
    .wr_clk  (dbg_clk),
    .wr_rst  (dbg_rst),
    .wr_en   (dbg_wr_en),
    .wr_data (dbg_wr_data),
    .wr_flag (r_at_dbg),
    .rd_clk  (proc_clk),
    .rd_rst  (proc_rst),
    .rd_en   (proc_rd_en),
    .rd_data (proc_rd_data),
    .rd_flag (r_at_proc)
  );

  assign proc_status = pack_status(w_at_proc, r_at_proc);
  assign dbg_status  = pack_status(w_at_dbg, r_at_dbg);
  assign irq_tx_free = ~w_at_proc;
  assign irq_rx_full = r_at_proc;
endmodule

// File: rtl/dcc_mbx_chk.sv
module dcc_mbx_chk #(
  parameter int DATA_W = 32
) (
  input logic              proc_clk,
  input logic              proc_rst,
  input logic              proc_wr_en,
  input logic              proc_rd_en,
  input logic [DATA_W-1:0] proc_rd_data,
  input logic [31:0]       proc_status,
  input logic              irq_tx_free,
  input logic              irq_rx_full,
  input logic              dbg_clk,
  input logic              dbg_rst,
  input logic              dbg_wr_en,
  input logic              dbg_rd_en,
  input logic [DATA_W-1:0] dbg_rd_data,
  input logic [31:0]       dbg_status
);
  p_wset_r1: assert property (@(posedge proc_clk) disable iff (proc_rst)
    proc_wr_en && !proc_status[1] |=> proc_status[1]);

  p_wclr_r2: assert property (@(posedge dbg_clk) disable iff (dbg_rst)
    dbg_rd_en && dbg_status[1] |=> !dbg_status[1]);

  p_rset_r3: assert property (@(posedge dbg_clk) disable iff (dbg_rst)
    dbg_wr_en && !dbg_status[0] |=> dbg_status[0]);

  p_rclr_r3: assert property (@(posedge proc_clk) disable iff (proc_rst)
    proc_rd_en && proc_status[0] |=> !proc_status[0]);

  p_empty_dbg_r5: assert property (@(posedge dbg_clk) disable iff (dbg_rst)
    dbg_rd_en && !dbg_status[1] |=> $stable(dbg_rd_data));

  p_empty_proc_r5: assert property (@(posedge proc_clk) disable iff (proc_rst)
    proc_rd_en && !proc_status[0] |=> $stable(proc_rd_data));

  p_hi_zero_proc_r6: assert property (@(posedge proc_clk) disable iff (proc_rst)
    proc_status[31:2] == '0);

  p_hi_zero_dbg_r6: assert property (@(posedge dbg_clk) disable iff (dbg_rst)
    dbg_status[31:2] == '0);

  p_irq_r7: assert property (@(posedge proc_clk) disable iff (proc_rst)
    (irq_tx_free != proc_status[1]) && (irq_rx_full == proc_status[0]));
endmodule

bind dcc_mbx dcc_mbx_chk #(.DATA_W(DATA_W)) u_chk (
  .proc_clk     (proc_clk),
  .proc_rst     (proc_rst),
  .proc_wr_en   (proc_wr_en),
  .proc_rd_en   (proc_rd_en),
  .proc_rd_data (proc_rd_data),
  .proc_status  (proc_status),
  .irq_tx_free  (irq_tx_free),
  .irq_rx_full  (irq_rx_full),
  .dbg_clk      (dbg_clk),
  .dbg_rst      (dbg_rst),
  .dbg_wr_en    (dbg_wr_en),
  .dbg_rd_en    (dbg_rd_en),
  .dbg_rd_data  (dbg_rd_data),
  .dbg_status   (dbg_status)
);

// File: tb/dcc_mbx_bench.sv
module dcc_mbx_bench;
  localparam int DW = 32;
  localparam int SS = 2;

  logic          proc_clk = 1'b0, dbg_clk = 1'b0;
  logic          proc_rst = 1'b1, dbg_rst = 1'b1;
  logic          proc_wr_en = 1'b0, proc_rd_en = 1'b0;
  logic          dbg_wr_en = 1'b0, dbg_rd_en = 1'b0;
  logic [DW-1:0] proc_wr_data = '0, dbg_wr_data = '0;
  logic [DW-1:0] proc_rd_data, dbg_rd_data;
  logic [31:0]   proc_status, dbg_status;
  logic          irq_tx_free, irq_rx_full;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4    proc_clk = ~proc_clk;
  always #6.5  dbg_clk  = ~dbg_clk;

  dcc_mbx #(.DATA_W(DW), .SYNC_STAGES(SS)) u_dcc_mbx (
    .proc_clk(proc_clk), .proc_rst(proc_rst), .proc_wr_en(proc_wr_en),
    .proc_wr_data(proc_wr_data), .proc_rd_en(proc_rd_en), .proc_rd_data(proc_rd_data),
    .proc_status(proc_status), .irq_tx_free(irq_tx_free), .irq_rx_full(irq_rx_full),
    .dbg_clk(dbg_clk), .dbg_rst(dbg_rst), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_data(dbg_wr_data), .dbg_rd_en(dbg_rd_en), .dbg_rd_data(dbg_rd_data),
    .dbg_status(dbg_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic proc_write(input logic [DW-1:0] d);
    @(negedge proc_clk); proc_wr_en = 1'b1; proc_wr_data = d;
    @(negedge proc_clk); proc_wr_en = 1'b0;
  endtask

  task automatic proc_read();
    @(negedge proc_clk); proc_rd_en = 1'b1;
    @(negedge proc_clk); proc_rd_en = 1'b0;
  endtask

  task automatic dbg_write(input logic [DW-1:0] d);
    @(negedge dbg_clk); dbg_wr_en = 1'b1; dbg_wr_data = d;
    @(negedge dbg_clk); dbg_wr_en = 1'b0;
  endtask

  task automatic dbg_read();
    @(negedge dbg_clk); dbg_rd_en = 1'b1;
    @(negedge dbg_clk); dbg_rd_en = 1'b0;
  endtask

  // R9: the other domain must follow within SS+1 of its own cycles
  task automatic wait_dbg(input int pos, input logic val, input string tag);
    int n = 0;
    while (dbg_status[pos] !== val && n < SS + 1) begin
      @(negedge dbg_clk); n++;
    end
    chk(tag, {31'b0, dbg_status[pos]}, {31'b0, val});
  endtask

  task automatic wait_proc(input int pos, input logic val, input string tag);
    int n = 0;
    while (proc_status[pos] !== val && n < SS + 1) begin
      @(negedge proc_clk); n++;
    end
    chk(tag, {31'b0, proc_status[pos]}, {31'b0, val});
  endtask

  task automatic send_out(input logic [DW-1:0] v);
    proc_write(v);
    chk("R1 W set at proc", proc_status, 32'h2);
    chk("R7 tx_free low", {31'b0, irq_tx_free}, 32'h0);
    wait_dbg(1, 1'b1, "R9 W reaches dbg");
    dbg_read();
    chk("R2 dbg read data", dbg_rd_data, v);
    chk("R2 W clear at dbg", dbg_status, 32'h0);
    wait_proc(1, 1'b0, "R9 W clear reaches proc");
    chk("R7 tx_free high", {31'b0, irq_tx_free}, 32'h1);
  endtask

  task automatic send_in(input logic [DW-1:0] v);
    dbg_write(v);
    chk("R3 R set at dbg", dbg_status, 32'h1);
    wait_proc(0, 1'b1, "R9 R reaches proc");
    chk("R7 rx_full high", {31'b0, irq_rx_full}, 32'h1);
    chk("R6 proc status R", proc_status, 32'h1);
    proc_read();
    chk("R3 proc read data", proc_rd_data, v);
    chk("R3 R clear at proc", proc_status, 32'h0);
    chk("R7 rx_full low", {31'b0, irq_rx_full}, 32'h0);
    wait_dbg(0, 1'b0, "R9 R clear reaches dbg");
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    if (i < DW)            return {{(DW-1){1'b0}}, 1'b1} << i;
    else if (i == DW)      return '0;
    else if (i == DW + 1)  return '1;
    else if (i == DW + 2)  return {(DW/2){2'b10}};
    else if (i == DW + 3)  return {(DW/2){2'b01}};
    else                   return DW'(i) * 32'h9E37_79B9;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge proc_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge dbg_clk);
    // R8 reset state
    chk("R8 proc status", proc_status, 32'h0);
    chk("R8 dbg status", dbg_status, 32'h0);
    chk("R8 proc rd data", proc_rd_data, 32'h0);
    chk("R8 dbg rd data", dbg_rd_data, 32'h0);
    chk("R8 tx_free", {31'b0, irq_tx_free}, 32'h1);
    chk("R8 rx_full", {31'b0, irq_rx_full}, 32'h0);
    @(negedge proc_clk) proc_rst = 1'b0;
    @(negedge dbg_clk)  dbg_rst  = 1'b0;
    repeat (3) @(negedge proc_clk);

    for (int i = 0; i < DW + 8; i++) send_out(pat(i));
    for (int i = 0; i < DW + 8; i++) send_in(~pat(i));

    // R4: second outbound write while W is set is dropped
    proc_write(32'h1111_2222);
    proc_write(32'h3333_4444);
    chk("R4 W still set", proc_status, 32'h2);
    wait_dbg(1, 1'b1, "R9 W at dbg");
    dbg_read();
    chk("R4 outbound word kept", dbg_rd_data, 32'h1111_2222);
    wait_proc(1, 1'b0, "R9 W clear");

    // R4: second inbound write while R is set is dropped
    dbg_write(32'h5555_6666);
    dbg_write(32'h7777_8888);
    chk("R4 R still set", dbg_status, 32'h1);
    wait_proc(0, 1'b1, "R9 R at proc");
    proc_read();
    chk("R4 inbound word kept", proc_rd_data, 32'h5555_6666);
    wait_dbg(0, 1'b0, "R9 R clear");

    // R5: reads of empty registers change nothing
    repeat (4) @(negedge dbg_clk);
    dbg_read();
    chk("R5 dbg rd data held", dbg_rd_data, 32'h1111_2222);
    chk("R5 dbg status held", dbg_status, 32'h0);
    proc_read();
    chk("R5 proc rd data held", proc_rd_data, 32'h5555_6666);
    chk("R5 proc status held", proc_status, 32'h0);

    // R6: both flags set at once, both domains
    fork
      proc_write(32'hCAFE_0001);
      dbg_write(32'hBEEF_0002);
    join
    repeat (SS + 2) @(negedge dbg_clk);
    @(negedge proc_clk);
    chk("R6 proc status both", proc_status, 32'h3);
    chk("R6 dbg status both", dbg_status, 32'h3);
    fork
      dbg_read();
      proc_read();
    join
    chk("R2 concurrent dbg data", dbg_rd_data, 32'hCAFE_0001);
    chk("R3 concurrent proc data", proc_rd_data, 32'hBEEF_0002);
    repeat (SS + 2) @(negedge dbg_clk);
    @(negedge proc_clk);
    chk("R6 proc status idle", proc_status, 32'h0);
    chk("R6 dbg status idle", dbg_status, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule